// File: doc/BRIEF.md
# Sparse-Key Ring Encryption Core

This block encrypts a binary message polynomial in the truncated polynomial ring of degree bound 107 with coefficients modulo 64. It produces the cipher polynomial e = r*h + m one coefficient at a time. The public key h lives in a fixed internal lookup table. The random blinding polynomial r has binary coefficients and arrives serially, one bit per clock. The block keeps only the degrees of the non-zero bits of r and never stores r itself.

The key observation is that r has only a few set bits. Each cipher coefficient is therefore the sum of a handful of key entries, and one 6-bit adder is the only arithmetic the block needs. A host raises `enc_i` and then shifts in the bits of r, lowest degree first. During the run, `m_bit_i` must present the message bit for the coefficient that `cur_idx_o` names. Each finished coefficient appears on `coef_o` for one cycle, with its index, under a `done_o` pulse.

Top module: `sparse_ring_enc`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low.
- R2: Key entry i is h[i] = (7*i*i + 3*i + 1) mod 64. Output coefficient k equals (sum over the kept degrees j of h[(k - j) mod 107] + m[k]) mod 64.
- R3: The key address (k - j) wraps modulo 107, never modulo 128. A degree j greater than k selects entry k - j + 107.
- R4: Only the first 5 set bits of r, in order of rising degree, are kept. Any later set bits have no effect on the output.
- R5: If r has fewer than 5 set bits, the empty slots add nothing. An all-zero r yields e[k] = m[k].
- R6: `enc_i` is sampled at a clock edge while the core is idle, and `busy_o` is high after that edge. Bit j of r is sampled at edge j+1 after it. Coefficient k is presented after edge 107 + 6*(k+1).
- R7: `done_o` is a one-cycle pulse. `coef_idx_o` counts 0 to 106 across the pulses of a run, and `busy_o` falls after the last pulse.
- R8: `enc_i` has no effect while `busy_o` is high. The timing and the values of the run in progress are unchanged.
- R9: The accumulated sum wraps modulo 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_i | input | 1 | Start request, honoured only when idle |
| r_bit_i | input | 1 | Serial bit of r, lowest degree first |
| m_bit_i | input | 1 | Message bit for coefficient `cur_idx_o` |
| busy_o | output | 1 | High from start until the last coefficient |
| cur_idx_o | output | 7 | Coefficient index currently being formed |
| done_o | output | 1 | One-cycle strobe for a finished coefficient |
| coef_o | output | 6 | Cipher coefficient, valid with `done_o` |
| coef_idx_o | output | 7 | Index of the coefficient on `coef_o` |

## Verification
The hardest case to reach is a run where the wrap rules really matter. That needs a stored degree above many output indices, so the address crosses the ring boundary, and a sum of five large key entries that overflows 6 bits. The stimulus gets there with r vectors that place set bits at degrees 104 to 106 and at scattered degrees, paired with all-ones messages. Separate runs add a sixth and a seventh set bit, an all-zero r, and repeated `enc_i` pulses during a run. Each run compares all 107 coefficients and their strobe cycles against a model built from the requirements.

// File: rtl/sparse_ring_enc.sv
module sparse_ring_enc #(
  parameter int N  = 107,
  parameter int QW = 6,
  parameter int DR = 5,
  parameter int IW = $clog2(N),
  parameter int SW = $clog2(DR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_i,
  input  logic          r_bit_i,
  input  logic          m_bit_i,
  output logic          busy_o,
  output logic [IW-1:0] cur_idx_o,
  output logic          done_o,
  output logic [QW-1:0] coef_o,
  output logic [IW-1:0] coef_idx_o
);
  localparam logic [IW-1:0] LAST  = IW'(N - 1);
  localparam logic [SW-1:0] SLAST = SW'(DR - 1);
  localparam logic [SW-1:0] SCAP  = SW'(DR);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_MUL, S_ADD} st_t;

  st_t           st;
  logic [IW-1:0] ctr;
  logic [SW-1:0] step, nz;
  logic [IW-1:0] deg [DR];
  logic [DR-1:0] vld;
  logic [QW-1:0] acc;
  logic [IW:0]   a_wide;
  logic [IW-1:0] addr;
  logic [QW-1:0] term;

  function automatic logic [QW-1:0] hkey(input logic [IW-1:0] i);
    int unsigned t;
    t = 7 * int'(i) * int'(i) + 3 * int'(i) + 1;
    return QW'(t);
  endfunction

  always_comb begin
    if (ctr >= deg[0]) a_wide = {1'b0, ctr} - {1'b0, deg[0]};
    else               a_wide = {1'b0, ctr} + (IW+1)'(N) - {1'b0, deg[0]};
  end
  assign addr      = a_wide[IW-1:0];
  assign term      = vld[0] ? hkey(addr) : '0;
  assign busy_o    = (st != S_IDLE);
  assign cur_idx_o = ctr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ctr        <= '0;
      step       <= '0;
      nz         <= '0;
      vld        <= '0;
      acc        <= '0;
      done_o     <= 1'b0;
      coef_o     <= '0;
      coef_idx_o <= '0;
      for (int i = 0; i < DR; i++) deg[i] <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        S_IDLE: if (enc_i) begin
          st  <= S_LOAD;
          ctr <= '0;
          nz  <= '0;
          vld <= '0;
        end
        S_LOAD: begin
          if (r_bit_i && nz < SCAP) begin
            deg[nz] <= ctr;
            vld[nz] <= 1'b1;
            nz      <= nz + 1'b1;
          end
          if (ctr == LAST) begin
            st   <= S_MUL;
            ctr  <= '0;
            step <= '0;
            acc  <= '0;
          end else ctr <= ctr + 1'b1;
        end
        S_MUL: begin
          acc <= acc + term;
          for (int i = 0; i < DR - 1; i++) deg[i] <= deg[i+1];
          deg[DR-1] <= deg[0];
          vld       <= {vld[0], vld[DR-1:1]};
          step      <= step + 1'b1;
          if (step == SLAST) st <= S_ADD;
        end
        S_ADD: begin
          coef_o     <= acc + QW'(m_bit_i);
          coef_idx_o <= ctr;
          done_o     <= 1'b1;
          acc        <= '0;
          step       <= '0;
          if (ctr == LAST) st <= S_IDLE;
          else begin
            ctr <= ctr + 1'b1;
            st  <= S_MUL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> coef_idx_o <= LAST);
  a_r6_busy_mid_run: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && coef_idx_o != LAST) |-> busy_o);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MUL) |=> (st == S_MUL || st == S_ADD));
  a_r4_slot_cap: assert property (@(posedge clk) disable iff (!rst_n)
    nz <= SCAP);
  a_r6_load_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && ctr != LAST) |=> st == S_LOAD);
endmodule

// File: tb/sparse_ring_enc_tb_top.sv
module sparse_ring_enc_tb_top;
  localparam int N = 107, DR = 5, LIMIT = 200000;

  logic clk = 1'b0, rst_n = 1'b0, enc = 1'b0, r_bit = 1'b0, m_bit;
  logic busy, done;
  logic [6:0] cur_idx, coef_idx;
  logic [5:0] coef;
  bit r_vec [N];
  bit m_vec [N];
  int exp_c [N];
  int tests = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always_comb m_bit = (cur_idx < 7'(N)) ? m_vec[cur_idx] : 1'b0;

  sparse_ring_enc dut_i (.clk(clk), .rst_n(rst_n), .enc_i(enc), .r_bit_i(r_bit),
    .m_bit_i(m_bit), .busy_o(busy), .cur_idx_o(cur_idx), .done_o(done),
    .coef_o(coef), .coef_idx_o(coef_idx));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic int hk(input int i);
    return (7 * i * i + 3 * i + 1) % 64;
  endfunction

  function automatic void model();
    int d [$];
    for (int j = 0; j < N; j++) if (r_vec[j] && d.size() < DR) d.push_back(j);
    for (int k = 0; k < N; k++) begin
      int s = int'(m_vec[k]);
      foreach (d[x]) s += hk((k - d[x] + N) % N);
      exp_c[k] = s % 64;
    end
  endfunction

  task automatic run_case(input string tag, input bit hammer);
    int nd = 0;
    int last_edge = N + N * (DR + 1);
    model();
    @(negedge clk); enc = 1'b1;
    @(posedge clk); #1;
    chk(busy === 1'b1, {tag, " R6 busy after start"}, int'(busy), 1);
    for (int e = 1; e <= last_edge + 3; e++) begin
      @(negedge clk);
      enc   = hammer && (e % 37 == 5);
      r_bit = (e <= N) ? r_vec[e-1] : 1'b0;
      @(posedge clk); #1;
      if (done) begin
        chk(int'(coef_idx) == nd, {tag, " R7 index order"}, int'(coef_idx), nd);
        chk(e == N + (nd + 1) * (DR + 1), {tag, " R6 strobe cycle"}, e, N + (nd + 1) * (DR + 1));
        if (nd < N)
          chk(int'(coef) == exp_c[nd], {tag, " R2 coefficient value"}, int'(coef), exp_c[nd]);
        nd++;
      end
      if (e == last_edge)
        chk(busy === 1'b0, {tag, " R7 busy falls after last"}, int'(busy), 0);
    end
    enc = 1'b0;
    chk(nd == N, {tag, " R7 strobe count"}, nd, N);
  endtask

  task automatic clear_vecs();
    for (int i = 0; i < N; i++) begin r_vec[i] = 0; m_vec[i] = 0; end
  endtask

  task automatic t_reset();
    #1;
    chk(busy === 1'b0 && done === 1'b0, "R1 reset state", int'({busy, done}), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(busy === 1'b0 && done === 1'b0, "R1 idle after reset", int'({busy, done}), 0);
  endtask

  task automatic t_basic();
    clear_vecs();
    r_vec[3] = 1; r_vec[20] = 1; r_vec[41] = 1; r_vec[77] = 1; r_vec[90] = 1;
    for (int i = 0; i < N; i++) m_vec[i] = (i % 3 == 1);
    run_case("R2 basic", 0);
  endtask

  task automatic t_wrap();
    clear_vecs();
    r_vec[0] = 1; r_vec[104] = 1; r_vec[105] = 1; r_vec[106] = 1; r_vec[60] = 1;
    for (int i = 0; i < N; i++) m_vec[i] = 1;
    run_case("R3 R9 wrap", 0);
  endtask

  task automatic t_extra();
    clear_vecs();
    r_vec[1] = 1; r_vec[9] = 1; r_vec[30] = 1; r_vec[31] = 1;
    r_vec[50] = 1; r_vec[70] = 1; r_vec[100] = 1;
    for (int i = 0; i < N; i++) m_vec[i] = (i % 2 == 0);
    run_case("R4 extra ones", 0);
  endtask

  task automatic t_sparse();
    clear_vecs();
    for (int i = 0; i < N; i++) m_vec[i] = (i % 5 < 2);
    run_case("R5 zero r", 0);
    clear_vecs();
    r_vec[55] = 1; r_vec[106] = 1;
    m_vec[0] = 1; m_vec[106] = 1;
    run_case("R5 two ones", 0);
  endtask

  task automatic t_enc_busy();
    clear_vecs();
    r_vec[7] = 1; r_vec[15] = 1; r_vec[88] = 1; r_vec[99] = 1; r_vec[102] = 1;
    for (int i = 0; i < N; i++) m_vec[i] = (i % 4 == 3);
    run_case("R8 enc while busy", 1);
    repeat (4) @(posedge clk); #1;
    chk(busy === 1'b0 && done === 1'b0, "R8 stays idle", int'({busy, done}), 0);
  endtask

  initial begin
    #(LIMIT * 5);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, LIMIT);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_extra();
    t_sparse();
    t_enc_busy();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule